// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block turns the compare events of a small up-counting timer into a level on one device pin. A compare-mode setting decides what a compare event does to an output flip-flop (hold, toggle, clear, set, or a pulse-width pattern). A waveform-mode setting decides how the counter runs: free-running, cleared on a compare, or free-running with pulse-width output. When the compare mode is nonzero, the pin shows the output flip-flop instead of the general-purpose port latch. The pin is driven only while its direction bit selects output.

Software writes the modes through one control strobe. That strobe also carries a force bit, which applies a compare action at once in the non pulse-width modes. This lets the flip-flop be preset before the pin is handed over. A second strobe loads the compare value. The counter is included so that the unit can run on its own.

Top module: `cmp_pin_unit`

## Requirements
- R1: While `rst` is high and at the first sample after it, `pin_out`, `pin_oe`, `match_evt` and `cnt_out` are all 0. Both mode settings reset to 00.
- R2: `pin_oe` equals the `port_dir` of the previous cycle, whatever the modes are.
- R3: When the active compare mode is nonzero, `pin_out` shows the previous-cycle output flip-flop. When it is 00, `pin_out` shows the previous-cycle `port_q`. The waveform mode plays no part in this choice.
- R4: When the compare mode is 00, a compare event leaves the output flip-flop unchanged.
- R5: A compare-mode write is stored as pending. The first compare event after the write cycle applies the new action and makes the setting active. The active setting drives the pin override and the pulse-width bottom action. A compare event in the same cycle as the write still uses the old setting.
- R6: In the non pulse-width waveform modes, a compare event acts as follows: mode 01 toggles the flip-flop, 10 clears it and 11 sets it.
- R7: Waveform modes 10 and 11 are pulse-width modes, and the counter wraps from 255 to 0 in them. With compare mode 10, a compare clears the flip-flop and the wrap (bottom) sets it. Mode 11 does the reverse. Mode 01 does nothing. When a compare and a bottom coincide, the bottom action wins.
- R8: In waveform modes 00 and 01, a control write with the force bit set applies the written compare mode's action to the flip-flop at the next edge. This presets the level before the override is active.
- R9: The force bit is ignored in the pulse-width modes. It never raises `match_evt` and never alters the count.
- R10: Waveform mode 00 counts freely and wraps. Mode 01 clears the count to 0 on the edge after the count equals the compare value. The compare mode has no effect on counting. `match_evt` is high in the cycle after the count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Control write strobe |
| ctrl_cmode | input | 2 | Compare mode written on `wr_ctrl` |
| ctrl_wmode | input | 2 | Waveform mode written on `wr_ctrl` |
| ctrl_force | input | 1 | Force bit written on `wr_ctrl` |
| wr_cmp | input | 1 | Compare value write strobe |
| cmp_data | input | CNT_W | Compare value |
| port_q | input | 1 | General-purpose port latch value |
| port_dir | input | 1 | Pin direction, 1 = output |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |
| cnt_out | output | CNT_W | Current count |
| match_evt | output | 1 | Registered compare event |

## Verification
Most faults in this block hide until a compare or bottom event exposes them. A wrong output flip-flop appears on `pin_out` one cycle after the override engages. A wrong pending or active mode shows only at the next compare event, so it can stay hidden for up to a full counter period. A corrupted count shifts every later `match_evt` and pin edge. A reference model is compared on every cycle, so any of these faults is reported within one period of the event that exposes it.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    CM_OFF = 2'b00,
    CM_TOG = 2'b01,
    CM_CLR = 2'b10,
    CM_SET = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    WM_FREE = 2'b00,
    WM_CTC  = 2'b01,
    WM_PWMA = 2'b10,
    WM_PWMB = 2'b11
  } wmode_e;

  function automatic logic is_pwm(wmode_e w);
    return w[1];
  endfunction

  // action of a compare event outside the pulse-width modes
  function automatic logic plain_act(cmode_e c, logic cur);
    case (c)
      CM_TOG:  return ~cur;
      CM_CLR:  return 1'b0;
      CM_SET:  return 1'b1;
      default: return cur;
    endcase
  endfunction

  // pulse-width action: at_bot selects the bottom edge, else the compare edge
  function automatic logic pwm_act(cmode_e c, logic at_bot, logic cur);
    case (c)
      CM_CLR:  return at_bot;
      CM_SET:  return ~at_bot;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/ocp_counter.sv
module ocp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             ctc,
  input  logic             pwm,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             match,
  output logic             bottom,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assign match  = (cnt == cmp);
  assign bottom = pwm && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cmp       <= '0;
      match_evt <= 1'b0;
    end else begin
      if (wr_cmp) cmp <= cmp_data;
      if (ctc && match) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      match_evt <= match;
    end
  end
endmodule

// File: rtl/ocp_mode_ctl.sv
module ocp_mode_ctl
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [1:0] ctrl_cmode,
  input  logic [1:0] ctrl_wmode,
  input  logic       ctrl_force,
  input  logic       match,
  input  logic       bottom,
  output wmode_e     wm,
  output cmode_e     cm_pend,
  output cmode_e     cm_act,
  output logic       ocf
);
  logic   ocf_nx;
  cmode_e wr_cm;

  assign wr_cm = cmode_e'(ctrl_cmode);

  always_comb begin
    ocf_nx = ocf;
    if (wr_ctrl && ctrl_force && !is_pwm(wm)) begin
      ocf_nx = plain_act(wr_cm, ocf);
    end else if (is_pwm(wm)) begin
      if (match)  ocf_nx = pwm_act(cm_pend, 1'b0, ocf_nx);
      if (bottom) ocf_nx = pwm_act(cm_act, 1'b1, ocf_nx);
    end else if (match) begin
      ocf_nx = plain_act(cm_pend, ocf);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wm      <= WM_FREE;
      cm_pend <= CM_OFF;
      cm_act  <= CM_OFF;
      ocf     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wm      <= wmode_e'(ctrl_wmode);
        cm_pend <= wr_cm;
      end
      if (match) cm_act <= cm_pend;
      ocf <= ocf_nx;
    end
  end
endmodule

// File: rtl/ocp_pin_mux.sv
module ocp_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic ovr,
  input  logic ocf,
  input  logic port_q,
  input  logic port_dir,
  output logic pin_out,
  output logic pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= ovr ? ocf : port_q;
      pin_oe  <= port_dir;
    end
  end
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import ocp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [1:0]       ctrl_cmode,
  input  logic [1:0]       ctrl_wmode,
  input  logic             ctrl_force,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             port_q,
  input  logic             port_dir,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] cnt_out,
  output logic             match_evt
);
  wmode_e           wm_q;
  cmode_e           cm_pend_q;
  cmode_e           cm_act_q;
  logic             ocf_q;
  logic [CNT_W-1:0] cmp_q;
  logic             match_w;
  logic             bottom_w;

  ocp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .wr_cmp    (wr_cmp),
    .cmp_data  (cmp_data),
    .ctc       (wm_q == WM_CTC),
    .pwm       (is_pwm(wm_q)),
    .cnt       (cnt_out),
    .cmp       (cmp_q),
    .match     (match_w),
    .bottom    (bottom_w),
    .match_evt (match_evt)
  );

  ocp_mode_ctl u_mode (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (wr_ctrl),
    .ctrl_cmode (ctrl_cmode),
    .ctrl_wmode (ctrl_wmode),
    .ctrl_force (ctrl_force),
    .match      (match_w),
    .bottom     (bottom_w),
    .wm         (wm_q),
    .cm_pend    (cm_pend_q),
    .cm_act     (cm_act_q),
    .ocf        (ocf_q)
  );

  ocp_pin_mux u_pin (
    .clk      (clk),
    .rst      (rst),
    .ovr      (cm_act_q != CM_OFF),
    .ocf      (ocf_q),
    .port_q   (port_q),
    .port_dir (port_dir),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );
endmodule

// File: rtl/ocp_chk.sv
module ocp_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_ctrl,
  input logic             ctrl_force,
  input logic             port_dir,
  input logic             pin_out,
  input logic             pin_oe,
  input logic [CNT_W-1:0] cnt_out,
  input logic             match_evt,
  input logic [1:0]       wm,
  input logic [1:0]       cm_pend,
  input logic [1:0]       cm_act,
  input logic             ocf,
  input logic [CNT_W-1:0] cmp,
  input logic             match,
  input logic             bottom
);
  assert_oe_dir_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pin_oe == $past(port_dir));

  assert_override_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cm_act) != 2'b00) |-> pin_out == $past(ocf));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match && !bottom && cm_pend == 2'b00 && !(wr_ctrl && ctrl_force)))
      |-> $stable(ocf));

  assert_act_at_match_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(match)) |-> $stable(cm_act));

  assert_pwm_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wm[1] && match && !bottom && cm_pend == 2'b10)) |-> !ocf);

  assert_free_count_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wm) == 2'b00) |-> cnt_out == CNT_W'($past(cnt_out) + 1'b1));

  assert_ctc_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(match && wm == 2'b01)) |-> cnt_out == '0);

  assert_evt_source_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && match_evt) |-> $past(cnt_out == cmp));
endmodule

bind cmp_pin_unit ocp_chk #(.CNT_W(CNT_W)) u_ocp_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_ctrl    (wr_ctrl),
  .ctrl_force (ctrl_force),
  .port_dir   (port_dir),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .cnt_out    (cnt_out),
  .match_evt  (match_evt),
  .wm         (wm_q),
  .cm_pend    (cm_pend_q),
  .cm_act     (cm_act_q),
  .ocf        (ocf_q),
  .cmp        (cmp_q),
  .match      (match_w),
  .bottom     (bottom_w)
);

// File: tb/test_cmp_pin_unit.sv
module test_cmp_pin_unit;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_ctrl = 1'b0;
  logic [1:0]    ctrl_cmode = 2'b00;
  logic [1:0]    ctrl_wmode = 2'b00;
  logic          ctrl_force = 1'b0;
  logic          wr_cmp = 1'b0;
  logic [CW-1:0] cmp_data = '0;
  logic          port_q = 1'b0;
  logic          port_dir = 1'b1;
  logic          pin_out, pin_oe, match_evt;
  logic [CW-1:0] cnt_out;

  int    n_chk = 0;
  int    n_err = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [CW-1:0] m_cnt, m_cmp;
  logic [1:0]    m_wm, m_pend, m_act;
  logic          m_ocf, m_pin, m_oe, m_evt;

  always #2 clk = ~clk;

  cmp_pin_unit #(.CNT_W(CW)) i_cmp_pin_unit (
    .clk, .rst, .wr_ctrl, .ctrl_cmode, .ctrl_wmode, .ctrl_force,
    .wr_cmp, .cmp_data, .port_q, .port_dir,
    .pin_out, .pin_oe, .cnt_out, .match_evt
  );

  function automatic logic f_plain(logic [1:0] c, logic cur);
    if (c == 2'b01) return ~cur;
    if (c == 2'b10) return 1'b0;
    if (c == 2'b11) return 1'b1;
    return cur;
  endfunction

  function automatic logic f_next_ocf(logic cur, logic [1:0] wm, logic [1:0] pend,
                                      logic [1:0] act, logic mt, logic bt,
                                      logic frc, logic [1:0] wcm);
    logic v;
    v = cur;
    if (frc && !wm[1]) return f_plain(wcm, cur);
    if (wm[1]) begin
      if (mt && pend == 2'b10) v = 1'b0;
      if (mt && pend == 2'b11) v = 1'b1;
      if (bt && act == 2'b10) v = 1'b1;
      if (bt && act == 2'b11) v = 1'b0;
      return v;
    end
    if (mt) return f_plain(pend, cur);
    return cur;
  endfunction

  always @(posedge clk) begin
    logic mt, bt;
    mt = (m_cnt == m_cmp);
    bt = m_wm[1] && (m_cnt == 8'hFF);
    if (rst) begin
      m_cnt <= '0; m_cmp <= '0; m_wm <= 2'b00; m_pend <= 2'b00; m_act <= 2'b00;
      m_ocf <= 1'b0; m_pin <= 1'b0; m_oe <= 1'b0; m_evt <= 1'b0;
    end else begin
      m_cnt  <= (m_wm == 2'b01 && mt) ? '0 : m_cnt + 1'b1;
      if (wr_cmp) m_cmp <= cmp_data;
      if (wr_ctrl) begin m_wm <= ctrl_wmode; m_pend <= ctrl_cmode; end
      if (mt) m_act <= m_pend;
      m_ocf <= f_next_ocf(m_ocf, m_wm, m_pend, m_act, mt, bt, wr_ctrl && ctrl_force, ctrl_cmode);
      m_pin <= (m_act != 2'b00) ? m_ocf : port_q;
      m_oe  <= port_dir;
      m_evt <= mt;
    end
  end

  task automatic chk(string t, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got=%0h exp=%0h", t, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(tag, "pin_out", pin_out, m_pin);
      chk(tag, "pin_oe", pin_oe, m_oe);
      chk(tag, "cnt_out", cnt_out, m_cnt);
      chk(tag, "match_evt", match_evt, m_evt);
    end
  end

  task automatic ctl(logic [1:0] cm, logic [1:0] wm, logic f);
    @(negedge clk);
    wr_ctrl = 1'b1; ctrl_cmode = cm; ctrl_wmode = wm; ctrl_force = f;
    @(negedge clk);
    wr_ctrl = 1'b0; ctrl_force = 1'b0;
  endtask

  task automatic set_cmp(logic [CW-1:0] v);
    @(negedge clk);
    wr_cmp = 1'b1; cmp_data = v;
    @(negedge clk);
    wr_cmp = 1'b0;
  endtask

  task automatic run_rand(int n);
    repeat (n) begin
      @(negedge clk);
      port_q = 1'($urandom); port_dir = 1'($urandom);
    end
  endtask

  task automatic wait_cnt(logic [CW-1:0] v);
    while (cnt_out !== v) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    logic [CW-1:0] c0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "pin_out", pin_out, 0);
    chk("R1", "pin_oe", pin_oe, 0);
    chk("R1", "cnt_out", cnt_out, 0);
    chk("R1", "match_evt", match_evt, 0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // preload via force while override is still off
    tag = "R8";
    set_cmp(8'd200);
    ctl(2'b11, 2'b00, 1'b1);
    ctl(2'b10, 2'b00, 1'b1);
    ctl(2'b01, 2'b00, 1'b0);
    wait_cnt(8'd150);
    chk("R8", "pin_out before override", pin_out, port_q);
    wait_cnt(8'd210);
    chk("R8", "pin_out after toggle of preload", pin_out, 1);

    // mid-period mode write takes effect at the next compare
    tag = "R5";
    ctl(2'b10, 2'b00, 1'b0);
    wait_cnt(8'd250);
    chk("R5", "pin_out before next compare", pin_out, 1);
    wait_cnt(8'd210);
    chk("R5", "pin_out after next compare", pin_out, 0);

    // direction bit gates the pin
    tag = "R2";
    @(negedge clk); port_dir = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "pin_oe with dir cleared", pin_oe, 0);
    port_dir = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "pin_oe with dir set", pin_oe, 1);

    // force in PWM mode is ignored and does not touch counting
    tag = "R9";
    ctl(2'b10, 2'b10, 1'b0);
    run_rand(20);
    @(negedge clk);
    c0 = cnt_out;
    wr_ctrl = 1'b1; ctrl_cmode = 2'b11; ctrl_wmode = 2'b10; ctrl_force = 1'b1;
    @(negedge clk);
    wr_ctrl = 1'b0; ctrl_force = 1'b0;
    chk("R9", "cnt_out after PWM force", cnt_out, CW'(c0 + 1'b1));
    run_rand(300);

    // non-PWM encodings
    tag = "R6";
    for (int w = 0; w < 2; w++)
      for (int c = 1; c < 4; c++) begin
        set_cmp((c == 1) ? 8'd5 : (c == 2) ? 8'd0 : 8'd255);
        ctl(2'(c), 2'(w), 1'b0);
        run_rand(300);
        ctl(2'(c ^ 3), 2'(w), 1'b1);
        run_rand(40);
      end

    tag = "R4";
    ctl(2'b00, 2'b01, 1'b0);
    set_cmp(8'd9);
    run_rand(120);
    ctl(2'b00, 2'b01, 1'b1);
    run_rand(60);

    // PWM encodings including compare at bottom and top
    tag = "R7";
    for (int w = 2; w < 4; w++)
      for (int c = 1; c < 4; c++)
        for (int k = 0; k < 3; k++) begin
          set_cmp((k == 0) ? 8'd0 : (k == 1) ? 8'd100 : 8'd255);
          ctl(2'(c), 2'(w), 1'b0);
          run_rand(300);
        end

    tag = "R10";
    for (int i = 0; i < 8; i++) begin
      set_cmp(CW'($urandom % 24));
      ctl(2'(i % 4), 2'b01, 1'b0);
      run_rand(80);
    end

    // random mix of all settings
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      port_q = 1'($urandom); port_dir = 1'($urandom);
      wr_ctrl = ($urandom % 12) == 0;
      ctrl_cmode = 2'($urandom); ctrl_wmode = 2'($urandom);
      ctrl_force = 1'($urandom);
      wr_cmp = ($urandom % 25) == 0;
      cmp_data = (($urandom % 2) == 0) ? CW'($urandom % 16) : CW'($urandom);
    end
    @(negedge clk);
    wr_ctrl = 1'b0; wr_cmp = 1'b0; ctrl_force = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule